// File: doc/BRIEF.md
# DSP Data Address Generator

This block produces the memory addresses for the load and store micro-operations of a signal-processing core. It holds two banks of eight register sets. Each set has four registers: an index, a modify, a length and a base. A request names one set and says how to form the address. In post-modify form, the current index is sent out and the index is then advanced. In offset form, the index plus an offset is sent out and the index is left as it is.

The step added to the index is either the set's signed modify register or a signed immediate carried by the request. When the set's length is nonzero, the updated index is folded back into the window that runs from base up to base plus length, so the set acts as a circular buffer. When bit-reverse is requested, the addition is done in reversed bit order over the low `BREV_W` index bits, which gives the access order of a radix-2 transform.

A mode input chooses whether requests use the primary bank or the alternate bank. A write port loads any register of either bank. The address for a request appears one cycle after the request.

Top module: `dag_top`

## Requirements
- R1: After reset every register of both banks reads zero and `addr_valid_o` is low.
- R2: A register write on `wr_*` takes effect on the next clock edge, and a request in the following cycle sees the new value. `wr_kind_i` codes are 0 for index, 1 for modify, 2 for length and 3 for base.
- R3: A post-modify request (`req_pre_i`=0, `req_use_imm_i`=0) outputs the current index. The index then becomes index plus the signed modify register, taken modulo 2^32.
- R4: A post-modify request with `req_use_imm_i`=1 adds the signed `req_imm_i` instead of the modify register.
- R5: An offset request (`req_pre_i`=1) outputs index plus the step, where the step is the modify register or the immediate. The index is left unchanged.
- R6: With nonzero length, a post-modify result at or above base plus length is reduced by length.
- R7: With nonzero length, a post-modify result below base is increased by length.
- R8: With zero length, the post-modify update is plain addition with no wrap.
- R9: With `req_brev_i`=1, the new low `BREV_W` index bits are reverse(reverse(index) + reverse(step)), and the carry out of that sum is dropped. The upper bits are kept and no circular wrap applies.
- R10: `alt_sel_i`=0 selects the primary bank and 1 selects the alternate bank for requests. `wr_bank_i` selects the bank for writes. A request on one bank does not change the other bank.
- R11: When an index write and a post-modify update hit the same register in the same cycle, the written value is kept. The address output in that cycle is still the old index.
- R12: `addr_valid_o` is high in exactly the cycle after a cycle with `req_valid_i` high, and `addr_o` carries that request's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_bank_i | input | 1 | Write bank: 0 primary, 1 alternate |
| wr_set_i | input | 3 | Register set to write |
| wr_kind_i | input | 2 | Register in set: 0 index, 1 modify, 2 length, 3 base |
| wr_data_i | input | 32 | Write data |
| alt_sel_i | input | 1 | Request bank: 0 primary, 1 alternate |
| req_valid_i | input | 1 | Address request strobe |
| req_set_i | input | 3 | Register set used by the request |
| req_pre_i | input | 1 | 1 offset form without update, 0 post-modify |
| req_use_imm_i | input | 1 | 1 step from immediate, 0 from modify register |
| req_imm_i | input | 32 | Signed immediate step |
| req_brev_i | input | 1 | Bit-reversed update |
| addr_o | output | 32 | Generated address |
| addr_valid_o | output | 1 | Address valid, one cycle after a request |

## Verification
A register write and a post-modify update can both target the same index register in one cycle. The bench provokes this by driving an index write and a post-modify request for the same bank and set at the same clock edge. It then checks two things: the address returned is the old index, and a later zero-step offset request reads back the written value rather than the incremented one. The circular and bit-reverse paths are checked separately, on both sides of the window and across the carry out of the reversed field.

// File: rtl/dag_pkg.sv
package dag_pkg;
  parameter int unsigned DAG_AW = 32;

  typedef enum logic [1:0] {
    REG_I = 2'd0,
    REG_M = 2'd1,
    REG_L = 2'd2,
    REG_B = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic [DAG_AW-1:0] idx;
    logic [DAG_AW-1:0] mdf;
    logic [DAG_AW-1:0] len;
    logic [DAG_AW-1:0] base;
  } set_t;
endpackage

// File: rtl/dag_regfile.sv
module dag_regfile
  import dag_pkg::*;
#(
  parameter int unsigned N_SETS = 8,
  localparam int unsigned SW = $clog2(N_SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_bank_i,
  input  logic [SW-1:0]     wr_set_i,
  input  logic [1:0]        wr_kind_i,
  input  logic [DAG_AW-1:0] wr_data_i,
  input  logic              rd_bank_i,
  input  logic [SW-1:0]     rd_set_i,
  output set_t              rd_o,
  input  logic              upd_en_i,
  input  logic [DAG_AW-1:0] upd_idx_i
);
  set_t regs_q [2][N_SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < N_SETS; s++)
          regs_q[b][s] <= '0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        for (int s = 0; s < N_SETS; s++) begin
          // explicit write beats post-modify update on the index
          if (wr_en_i && wr_bank_i == 1'(b) && wr_set_i == SW'(s)) begin
            unique case (reg_kind_e'(wr_kind_i))
              REG_I: regs_q[b][s].idx  <= wr_data_i;
              REG_M: regs_q[b][s].mdf  <= wr_data_i;
              REG_L: regs_q[b][s].len  <= wr_data_i;
              REG_B: regs_q[b][s].base <= wr_data_i;
              default: ;
            endcase
          end
          if (upd_en_i && rd_bank_i == 1'(b) && rd_set_i == SW'(s) &&
              !(wr_en_i && wr_bank_i == 1'(b) && wr_set_i == SW'(s) &&
                reg_kind_e'(wr_kind_i) == REG_I))
            regs_q[b][s].idx <= upd_idx_i;
        end
      end
    end
  end

  assign rd_o = regs_q[rd_bank_i][rd_set_i];

  p_write_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == 2'd0 && upd_en_i &&
     wr_bank_i == rd_bank_i && wr_set_i == rd_set_i)
    |=> regs_q[$past(wr_bank_i)][$past(wr_set_i)].idx == $past(wr_data_i));

  p_no_update_keeps_idx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_en_i && !wr_en_i)
    |=> regs_q[$past(rd_bank_i)][$past(rd_set_i)].idx == $past(rd_o.idx));
endmodule

// File: rtl/dag_update.sv
module dag_update
  import dag_pkg::*;
#(
  parameter int unsigned BREV_W = 8,
  localparam int unsigned RW = (BREV_W >= DAG_AW) ? DAG_AW : BREV_W
) (
  input  set_t              cur_i,
  input  logic [DAG_AW-1:0] step_i,
  input  logic              brev_i,
  output logic [DAG_AW-1:0] next_o,
  output logic [DAG_AW-1:0] off_o
);
  logic [DAG_AW-1:0] sum, lim, circ, rev_next;
  logic [RW-1:0]     ri, rm, rs, rs_back;

  assign sum   = cur_i.idx + step_i;
  assign off_o = sum;
  assign lim   = cur_i.base + cur_i.len;

  always_comb begin
    circ = sum;
    if (cur_i.len != '0) begin
      if (sum >= lim)            circ = sum - cur_i.len;
      else if (sum < cur_i.base) circ = sum + cur_i.len;
    end
  end

  always_comb begin
    for (int k = 0; k < RW; k++) begin
      ri[k] = cur_i.idx[RW-1-k];
      rm[k] = step_i[RW-1-k];
    end
    rs = ri + rm;
    for (int k = 0; k < RW; k++) rs_back[k] = rs[RW-1-k];
  end

  generate
    if (RW < DAG_AW) begin : g_part
      assign rev_next = {cur_i.idx[DAG_AW-1:RW], rs_back};
    end else begin : g_full
      assign rev_next = rs_back;
    end
  endgenerate

  assign next_o = brev_i ? rev_next : circ;
endmodule

// File: rtl/dag_top.sv
module dag_top
  import dag_pkg::*;
#(
  parameter int unsigned N_SETS = 8,
  parameter int unsigned BREV_W = 8,
  localparam int unsigned SW = $clog2(N_SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_bank_i,
  input  logic [SW-1:0]     wr_set_i,
  input  logic [1:0]        wr_kind_i,
  input  logic [DAG_AW-1:0] wr_data_i,
  input  logic              alt_sel_i,
  input  logic              req_valid_i,
  input  logic [SW-1:0]     req_set_i,
  input  logic              req_pre_i,
  input  logic              req_use_imm_i,
  input  logic [DAG_AW-1:0] req_imm_i,
  input  logic              req_brev_i,
  output logic [DAG_AW-1:0] addr_o,
  output logic              addr_valid_o
);
  set_t              cur;
  logic [DAG_AW-1:0] step, next_idx, off_addr;
  logic              post_upd;

  assign step     = req_use_imm_i ? req_imm_i : cur.mdf;
  assign post_upd = req_valid_i && !req_pre_i;

  dag_regfile #(.N_SETS(N_SETS)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_bank_i (wr_bank_i),
    .wr_set_i  (wr_set_i),
    .wr_kind_i (wr_kind_i),
    .wr_data_i (wr_data_i),
    .rd_bank_i (alt_sel_i),
    .rd_set_i  (req_set_i),
    .rd_o      (cur),
    .upd_en_i  (post_upd),
    .upd_idx_i (next_idx)
  );

  dag_update #(.BREV_W(BREV_W)) u_upd (
    .cur_i  (cur),
    .step_i (step),
    .brev_i (req_brev_i),
    .next_o (next_idx),
    .off_o  (off_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o       <= '0;
      addr_valid_o <= 1'b0;
    end else begin
      addr_valid_o <= req_valid_i;
      if (req_valid_i) addr_o <= req_pre_i ? off_addr : cur.idx;
    end
  end

  p_valid_follows_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> addr_valid_o);

  p_idle_no_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !addr_valid_o);

  p_post_addr_is_index_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_upd |=> addr_o == $past(cur.idx));
endmodule

// File: tb/tb_dag_top.sv
module tb_dag_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_bank_i = 1'b0;
  logic [2:0]  wr_set_i = '0;
  logic [1:0]  wr_kind_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        alt_sel_i = 1'b0, req_valid_i = 1'b0;
  logic [2:0]  req_set_i = '0;
  logic        req_pre_i = 1'b0, req_use_imm_i = 1'b0, req_brev_i = 1'b0;
  logic [31:0] req_imm_i = '0;
  logic [31:0] addr_o;
  logic        addr_valid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  dag_top dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(bit bank, int set, int kind, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1; wr_bank_i = bank; wr_set_i = 3'(set); wr_kind_i = 2'(kind); wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 0;
  endtask

  task automatic rq(bit bank, int set, bit pre, bit imm_sel, logic [31:0] imm, bit brev,
                    output logic [31:0] a);
    @(negedge clk_i);
    alt_sel_i = bank; req_valid_i = 1; req_set_i = 3'(set); req_pre_i = pre;
    req_use_imm_i = imm_sel; req_imm_i = imm; req_brev_i = brev;
    @(posedge clk_i); #1;
    a = addr_o;
    check("R12 valid", 32'(addr_valid_o), 32'd1);
    req_valid_i = 0;
  endtask

  // zero-step offset request returns the index without changing it
  task automatic peek(bit bank, int set, output logic [31:0] a);
    rq(bank, set, 1, 1, 32'd0, 0, a);
  endtask

  task automatic t_reset();
    logic [31:0] a;
    check("R1 valid low", 32'(addr_valid_o), 32'd0);
    peek(0, 3, a); check("R1 idx0", a, 32'd0);
    peek(1, 7, a); check("R1 idx1", a, 32'd0);
    @(posedge clk_i); #1;
    check("R12 valid drops", 32'(addr_valid_o), 32'd0);
  endtask

  task automatic t_post();
    logic [31:0] a;
    wr(0, 0, 0, 32'h0000_0100);
    wr(0, 0, 1, 32'h0000_0010);
    peek(0, 0, a); check("R2 write seen", a, 32'h100);
    rq(0, 0, 0, 0, 0, 0, a); check("R3 addr", a, 32'h100);
    peek(0, 0, a); check("R3 idx+M", a, 32'h110);
    wr(0, 0, 1, 32'hFFFF_FFF8);
    rq(0, 0, 0, 0, 0, 0, a); check("R3 addr neg", a, 32'h110);
    peek(0, 0, a); check("R3 idx-8", a, 32'h108);
    rq(0, 0, 0, 1, 32'h0000_0020, 0, a); check("R4 addr", a, 32'h108);
    peek(0, 0, a); check("R4 idx+imm", a, 32'h128);
  endtask

  task automatic t_offset();
    logic [31:0] a;
    wr(0, 1, 0, 32'h0000_2000);
    wr(0, 1, 1, 32'h0000_0044);
    rq(0, 1, 1, 0, 0, 0, a); check("R5 I+M", a, 32'h2044);
    rq(0, 1, 1, 1, 32'hFFFF_FFFC, 0, a); check("R5 I+imm", a, 32'h1FFC);
    peek(0, 1, a); check("R5 idx kept", a, 32'h2000);
  endtask

  task automatic t_circ();
    logic [31:0] a;
    wr(0, 2, 3, 32'h0000_1000);
    wr(0, 2, 2, 32'h0000_0010);
    wr(0, 2, 0, 32'h0000_100C);
    wr(0, 2, 1, 32'h0000_0004);
    rq(0, 2, 0, 0, 0, 0, a); check("R6 addr", a, 32'h100C);
    peek(0, 2, a); check("R6 wrap up", a, 32'h1000);
    rq(0, 2, 0, 1, 32'hFFFF_FFFC, 0, a);
    peek(0, 2, a); check("R7 wrap down", a, 32'h100C);
    rq(0, 2, 0, 1, 32'hFFFF_FFFC, 0, a);
    peek(0, 2, a); check("R6 inside window", a, 32'h1008);
    wr(0, 2, 2, 32'h0);
    wr(0, 2, 0, 32'h0000_100C);
    rq(0, 2, 0, 0, 0, 0, a);
    peek(0, 2, a); check("R8 linear", a, 32'h1010);
  endtask

  task automatic t_brev();
    logic [31:0] a;
    wr(0, 4, 0, 32'h0000_0100);
    wr(0, 4, 1, 32'h0000_0080);
    wr(0, 4, 2, 32'h0000_0004);  // length ignored under bit-reverse
    rq(0, 4, 0, 0, 0, 1, a); check("R9 addr", a, 32'h100);
    peek(0, 4, a); check("R9 step1", a, 32'h180);
    rq(0, 4, 0, 0, 0, 1, a);
    peek(0, 4, a); check("R9 step2", a, 32'h140);
    rq(0, 4, 0, 0, 0, 1, a);
    peek(0, 4, a); check("R9 step3", a, 32'h1C0);
    wr(0, 4, 0, 32'h0000_01FF);
    rq(0, 4, 0, 0, 0, 1, a);
    peek(0, 4, a); check("R9 carry dropped", a, 32'h100);
  endtask

  task automatic t_bank();
    logic [31:0] a;
    wr(0, 5, 0, 32'h0000_0200);
    wr(1, 5, 0, 32'h0000_0500);
    wr(1, 5, 1, 32'h0000_0008);
    peek(0, 5, a); check("R10 primary", a, 32'h200);
    peek(1, 5, a); check("R10 alternate", a, 32'h500);
    rq(1, 5, 0, 0, 0, 0, a); check("R10 alt addr", a, 32'h500);
    peek(1, 5, a); check("R10 alt updated", a, 32'h508);
    peek(0, 5, a); check("R10 primary untouched", a, 32'h200);
  endtask

  task automatic t_collide();
    logic [31:0] a;
    wr(0, 6, 0, 32'h0000_0300);
    wr(0, 6, 1, 32'h0000_0004);
    @(negedge clk_i);
    wr_en_i = 1; wr_bank_i = 0; wr_set_i = 3'd6; wr_kind_i = 2'd0; wr_data_i = 32'h0000_0A00;
    alt_sel_i = 0; req_valid_i = 1; req_set_i = 3'd6; req_pre_i = 0;
    req_use_imm_i = 0; req_brev_i = 0;
    @(posedge clk_i); #1;
    check("R11 old addr", addr_o, 32'h300);
    wr_en_i = 0; req_valid_i = 0;
    peek(0, 6, a); check("R11 write wins", a, 32'h0A00);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    t_reset();
    t_post();
    t_offset();
    t_circ();
    t_brev();
    t_bank();
    t_collide();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule